// File: doc/BRIEF.md
# Repeated String Copy Engine

A sequencer that copies a run of equal-sized elements from one region of memory to another. Software loads a source pointer, a destination pointer, an element count, an element size code, a direction flag and an address-width mode, then pulses `start`. For each element the engine issues one read at the source address and then one write of the captured data to the destination address. It then moves both pointers by the element size and decrements the count. When the count reaches zero it pulses `done` and leaves the final pointers and count on its result outputs.

The memory side is a single request/ready port shared by reads and writes. Data travels on a 64-bit bus. Narrow elements occupy the low bytes and carry a matching byte-enable mask on writes. In the narrow address mode only the low 32 bits of each pointer take part, and stepping wraps inside that 32-bit space.

The controller has four states. `ST_IDLE` waits for `start`. It goes to `ST_READ`, or to `ST_DONE` when the count is zero. `ST_READ` holds the read request until `mem_ready`, then goes to `ST_WRITE`. `ST_WRITE` holds the write request until `mem_ready`, then goes back to `ST_READ`, or to `ST_DONE` when that write finished the last element. `ST_DONE` raises `done` for one cycle and returns to `ST_IDLE`.

Top module: `strcopy_engine`

## Requirements
- R1: After reset the engine is idle: `busy`, `done` and `mem_req` are low, and no memory request is made while idle.
- R2: After each element both pointers move by the same step. The step is 1, 2, 4 or 8 for `elem_size` codes 0, 1, 2 and 3. The pointers increase when `dir_down` is 0 and decrease when it is 1.
- R3: The count drops by one on each accepted write. When it reaches zero, `done` is raised and `src_out`, `dst_out` and `cnt_out` hold the final source pointer, the final destination pointer and zero.
- R4: Each element is exactly one read (`mem_we`=0) followed by one write (`mem_we`=1). A request holds its address and kind until `mem_ready` is high at a clock edge, and a write starts only after its read was accepted.
- R5: With `narrow_addr`=1, bits 63:32 of the input pointers are ignored. Pointer stepping wraps modulo 2^32, and bits 63:32 of `mem_addr`, `src_out` and `dst_out` are zero.
- R6: A start with a count of zero makes no memory access, raises `done` in the cycle after the start edge and returns the input pointers unchanged.
- R7: A write carries the low 2^`elem_size` bytes of the data read for that element. `mem_be` has exactly those low bits set, so destination bytes outside the element are untouched.
- R8: A `start` pulse while the engine is busy is ignored. The copy in progress finishes with its own operands.
- R9: `done` is a single-cycle pulse, and the engine is idle in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a copy with the operand inputs (ignored when busy) |
| src_in | input | 64 | Initial source pointer |
| dst_in | input | 64 | Initial destination pointer |
| cnt_in | input | 64 | Number of elements to copy |
| elem_size | input | 2 | Element size code: 0=1 byte, 1=2, 2=4, 3=8 |
| dir_down | input | 1 | 0 = pointers increase, 1 = pointers decrease |
| narrow_addr | input | 1 | 1 = 32-bit address space with wrap |
| busy | output | 1 | Copy in progress (any state but idle) |
| done | output | 1 | One-cycle completion pulse |
| src_out | output | 64 | Current and final source pointer |
| dst_out | output | 64 | Current and final destination pointer |
| cnt_out | output | 64 | Remaining element count |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 64 | Memory byte address |
| mem_wdata | output | 64 | Write data, element in the low bytes |
| mem_be | output | 8 | Write byte enables |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_rdata | input | 64 | Read data, valid when a read is accepted |

## Verification
A new `start` pulse can fall in the very cycle in which a write is accepted. In that cycle the engine updates its pointers and count, and a careless design could also reload its operands. The bench provokes this by raising `start` with different operands during the write phase of the first element, with memory always ready so that the write completes at that same edge. It judges the outcome from the final pointers, the count, the number of memory transactions and the destination contents, which must all match the original operands alone. The last accepted write and the count reaching zero also share an edge. This is judged by `done` appearing exactly one cycle later with a count of zero.

// File: rtl/strcopy_pkg.sv
package strcopy_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_DWORD = 2'd3
    } esize_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_DONE  = 2'd3
    } state_t;

endpackage

// File: rtl/strcopy_step.sv
module strcopy_step #(
    parameter int unsigned AW = 64,
    parameter int unsigned NW = 32
) (
    input  logic [AW-1:0] ptr,
    input  logic [1:0]    size,
    input  logic          down,
    input  logic          narrow,
    output logic [AW-1:0] nxt
);
    localparam logic [AW-1:0] NMASK = (AW'(1) << NW) - AW'(1);

    logic [AW-1:0] stride;
    logic [AW-1:0] moved;

    always_comb begin
        stride = AW'(1) << size;
        moved  = down ? (ptr - stride) : (ptr + stride);
        nxt    = narrow ? (moved & NMASK) : moved;
    end
endmodule

// File: rtl/strcopy_lanes.sv
module strcopy_lanes #(
    parameter int unsigned DW = 64
) (
    input  logic [1:0]      size,
    output logic [DW/8-1:0] be,
    output logic [DW-1:0]   dmask
);
    localparam int unsigned BW = DW / 8;

    for (genvar b = 0; b < BW; b++) begin : g_lane
        assign be[b]            = (32'(b) < (32'd1 << size));
        assign dmask[8*b +: 8]  = {8{be[b]}};
    end
endmodule

// File: rtl/strcopy_engine.sv
module strcopy_engine
    import strcopy_pkg::*;
#(
    parameter int unsigned AW = 64,
    parameter int unsigned DW = 64,
    parameter int unsigned CW = 64,
    parameter int unsigned NW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [AW-1:0]   src_in,
    input  logic [AW-1:0]   dst_in,
    input  logic [CW-1:0]   cnt_in,
    input  logic [1:0]      elem_size,
    input  logic            dir_down,
    input  logic            narrow_addr,
    output logic            busy,
    output logic            done,
    output logic [AW-1:0]   src_out,
    output logic [AW-1:0]   dst_out,
    output logic [CW-1:0]   cnt_out,
    output logic            mem_req,
    output logic            mem_we,
    output logic [AW-1:0]   mem_addr,
    output logic [DW-1:0]   mem_wdata,
    output logic [DW/8-1:0] mem_be,
    input  logic            mem_ready,
    input  logic [DW-1:0]   mem_rdata
);
    localparam int unsigned    BW    = DW / 8;
    localparam logic [AW-1:0]  NMASK = (AW'(1) << NW) - AW'(1);

    state_t          state_q, state_d;
    logic [AW-1:0]   src_q, dst_q;
    logic [CW-1:0]   cnt_q;
    logic [1:0]      size_q;
    logic            down_q;
    logic            narrow_q;
    logic [DW-1:0]   buf_q;

    logic [AW-1:0]   src_nx, dst_nx;
    logic [BW-1:0]   lane_be;
    logic [DW-1:0]   lane_mask;
    logic            rd_acc, wr_acc;

    strcopy_step #(.AW(AW), .NW(NW)) u_src_step (
        .ptr(src_q), .size(size_q), .down(down_q), .narrow(narrow_q), .nxt(src_nx)
    );
    strcopy_step #(.AW(AW), .NW(NW)) u_dst_step (
        .ptr(dst_q), .size(size_q), .down(down_q), .narrow(narrow_q), .nxt(dst_nx)
    );
    strcopy_lanes #(.DW(DW)) u_lanes (
        .size(size_q), .be(lane_be), .dmask(lane_mask)
    );

    assign rd_acc = (state_q == ST_READ)  && mem_ready;
    assign wr_acc = (state_q == ST_WRITE) && mem_ready;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = (cnt_in == '0) ? ST_DONE : ST_READ;
            ST_READ:  if (mem_ready) state_d = ST_WRITE;
            ST_WRITE: if (mem_ready) state_d = (cnt_q == CW'(1)) ? ST_DONE : ST_READ;
            ST_DONE:  state_d = ST_IDLE;
        endcase
    end

    // state and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            src_q    <= '0;
            dst_q    <= '0;
            cnt_q    <= '0;
            size_q   <= SZ_BYTE;
            down_q   <= 1'b0;
            narrow_q <= 1'b0;
            buf_q    <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start) begin
                src_q    <= narrow_addr ? (src_in & NMASK) : src_in;
                dst_q    <= narrow_addr ? (dst_in & NMASK) : dst_in;
                cnt_q    <= cnt_in;
                size_q   <= elem_size;
                down_q   <= dir_down;
                narrow_q <= narrow_addr;
            end
            if (rd_acc) begin
                buf_q <= mem_rdata & lane_mask;
            end
            if (wr_acc) begin
                src_q <= src_nx;
                dst_q <= dst_nx;
                cnt_q <= cnt_q - CW'(1);
            end
        end
    end

    // outputs
    always_comb begin
        busy      = (state_q != ST_IDLE);
        done      = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        mem_be    = '0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_READ: begin
                mem_req  = 1'b1;
                mem_addr = src_q;
            end
            ST_WRITE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = dst_q;
                mem_wdata = buf_q;
                mem_be    = lane_be;
            end
            ST_DONE:  done = 1'b1;
        endcase
    end

    assign src_out = src_q;
    assign dst_out = dst_q;
    assign cnt_out = cnt_q;

endmodule

// File: rtl/strcopy_engine_chk.sv
module strcopy_engine_chk #(
    parameter int unsigned AW = 64,
    parameter int unsigned CW = 64,
    parameter int unsigned BW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          done,
    input logic          mem_req,
    input logic          mem_we,
    input logic          mem_ready,
    input logic [AW-1:0] mem_addr,
    input logic [BW-1:0] mem_be,
    input logic [AW-1:0] src_out,
    input logic [AW-1:0] dst_out,
    input logic [CW-1:0] cnt_out,
    input logic          narrow
);
    logic wr_acc;
    assign wr_acc = mem_req && mem_we && mem_ready;

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);

    p_same_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_acc && !narrow) |=> (src_out - $past(src_out)) == (dst_out - $past(dst_out)));

    p_cnt_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_acc |=> cnt_out == $past(cnt_out) - CW'(1));

    p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> mem_req && (mem_we == $past(mem_we)) && (mem_addr == $past(mem_addr)));

    p_rd_then_wr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && mem_ready) |=> mem_req && mem_we);

    p_hi_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (narrow && busy) |-> (src_out[AW-1:32] == '0) && (dst_out[AW-1:32] == '0)
                             && (!mem_req || mem_addr[AW-1:32] == '0));

    p_be_shape_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> mem_be[0] && ((mem_be & (mem_be + BW'(1))) == '0));

    p_busy_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !wr_acc) |=> $stable(cnt_out) && $stable(src_out) && $stable(dst_out));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !busy);

endmodule

bind strcopy_engine strcopy_engine_chk #(.AW(AW), .CW(CW), .BW(DW/8)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
    .mem_req(mem_req), .mem_we(mem_we), .mem_ready(mem_ready),
    .mem_addr(mem_addr), .mem_be(mem_be),
    .src_out(src_out), .dst_out(dst_out), .cnt_out(cnt_out),
    .narrow(narrow_q)
);

// File: tb/strcopy_engine_tb.sv
`timescale 1ns/1ps
module strcopy_engine_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [63:0] src_in = '0, dst_in = '0, cnt_in = '0;
    logic [1:0]  elem_size = 2'd0;
    logic        dir_down = 1'b0, narrow_addr = 1'b0;
    logic        busy, done, mem_req, mem_we;
    logic [63:0] src_out, dst_out, cnt_out, mem_addr, mem_wdata;
    logic [7:0]  mem_be;
    logic        mem_ready = 1'b1;
    logic [63:0] mem_rdata = '0;

    int vectors = 0, miscompares = 0;
    int cycles = 0;
    int n_rd = 0, n_wr = 0, ord_err = 0;
    bit rd_pend = 0;
    bit stall_en = 0;
    logic [7:0] exp_be = 8'h01;
    logic [15:0] lfsr = 16'hACE1;
    logic [7:0] mem [longint unsigned];

    always #2 clk = ~clk;

    strcopy_engine u_dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .src_in(src_in), .dst_in(dst_in), .cnt_in(cnt_in),
        .elem_size(elem_size), .dir_down(dir_down), .narrow_addr(narrow_addr),
        .busy(busy), .done(done), .src_out(src_out), .dst_out(dst_out), .cnt_out(cnt_out),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_ready(mem_ready), .mem_rdata(mem_rdata)
    );

    function automatic logic [7:0] pat(input logic [63:0] a);
        return a[7:0] ^ a[15:8] ^ a[39:32] ^ 8'h3C;
    endfunction

    function automatic logic [7:0] rd_byte(input logic [63:0] a);
        if (mem.exists(a)) return mem[a];
        return pat(a);
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // memory model: ready and read data change at the falling edge
    always @(negedge clk) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        mem_ready = !stall_en || lfsr[1];
        for (int b = 0; b < 8; b++) mem_rdata[8*b +: 8] = rd_byte(mem_addr + 64'(b));
    end

    // transaction monitor
    always @(posedge clk) begin
        if (rst_n && mem_req && mem_ready) begin
            if (!mem_we) begin
                if (rd_pend) ord_err++;
                rd_pend = 1;
                n_rd++;
            end else begin
                if (!rd_pend) ord_err++;
                if (mem_be !== exp_be) ord_err++;
                rd_pend = 0;
                n_wr++;
                for (int b = 0; b < 8; b++)
                    if (mem_be[b]) mem[mem_addr + 64'(b)] = mem_wdata[8*b +: 8];
            end
        end
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                miscompares++;
                $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
                $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
                $finish;
            end
        end
    end

    function automatic logic [63:0] wrapm(input logic [63:0] a, input bit n32);
        return n32 ? {32'h0, a[31:0]} : a;
    endfunction

    // one complete copy plus checks of results, transactions and memory
    task automatic run_copy(input logic [63:0] s, input logic [63:0] d, input int n,
                            input logic [1:0] sz, input bit dn, input bit n32,
                            input bit stall, input bit collide, input string tag);
        logic [63:0] stp, s0, d0, es, ed, sa, da, guard;
        int wait_n;
        stp = 64'd1 << sz;
        s0 = wrapm(s, n32);
        d0 = wrapm(d, n32);
        es = wrapm(dn ? s0 - stp * 64'(n) : s0 + stp * 64'(n), n32);
        ed = wrapm(dn ? d0 - stp * 64'(n) : d0 + stp * 64'(n), n32);
        mem.delete();
        n_rd = 0; n_wr = 0; ord_err = 0; rd_pend = 0;
        exp_be = 8'((16'd1 << stp[3:0]) - 16'd1);
        stall_en = stall;
        @(negedge clk);
        src_in = s; dst_in = d; cnt_in = 64'(n);
        elem_size = sz; dir_down = dn; narrow_addr = n32;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (collide) begin
            // READ accepted at next edge; raise start during WRITE, accepted same edge
            @(negedge clk);
            src_in = 64'h7000; dst_in = 64'h7800; cnt_in = 64'd9;
            elem_size = 2'd3; dir_down = ~dn; narrow_addr = 1'b0;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        wait_n = 0;
        while (!done && wait_n < 5000) begin
            @(negedge clk);
            wait_n++;
        end
        check(done === 1'b1, {tag, " R3 done"}, 64'(done), 64'd1);
        check(cnt_out === 64'd0, {tag, " R3 final count"}, cnt_out, 64'd0);
        check(src_out === es, {tag, " R2 final src"}, src_out, es);
        check(dst_out === ed, {tag, " R2 final dst"}, dst_out, ed);
        check(n_rd == n && n_wr == n && ord_err == 0, {tag, " R4 transactions/order"},
              64'(n_rd) << 32 | 64'(n_wr) << 8 | 64'(ord_err), 64'(n) << 32 | 64'(n) << 8);
        for (int i = 0; i < n; i++) begin
            sa = wrapm(dn ? s0 - stp * 64'(i) : s0 + stp * 64'(i), n32);
            da = wrapm(dn ? d0 - stp * 64'(i) : d0 + stp * 64'(i), n32);
            for (int j = 0; j < 8; j++)
                if (64'(j) < stp)
                    check(rd_byte(da + 64'(j)) === pat(sa + 64'(j)), {tag, " R7 data"},
                          64'(rd_byte(da + 64'(j))), 64'(pat(sa + 64'(j))));
        end
        guard = dn ? d0 + stp : ed;
        check(rd_byte(guard) === pat(guard), {tag, " R7 guard byte untouched"},
              64'(rd_byte(guard)), 64'(pat(guard)));
        @(negedge clk);
        check(!done && !busy, {tag, " R9 single pulse, idle"}, {62'h0, done, busy}, 64'd0);
        stall_en = 0;
    endtask

    task automatic t_reset();
        check(!busy && !done && !mem_req, "R1 reset idle", {61'h0, busy, done, mem_req}, 64'd0);
        repeat (3) @(negedge clk);
        check(n_rd == 0 && n_wr == 0 && !mem_req, "R1 no access while idle", 64'(n_rd + n_wr), 64'd0);
    endtask

    task automatic t_zero_count();
        n_rd = 0; n_wr = 0;
        @(negedge clk);
        src_in = 64'h0000_1234_0000_0100; dst_in = 64'h200; cnt_in = 64'd0;
        elem_size = 2'd2; dir_down = 1'b0; narrow_addr = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(done === 1'b1, "R6 done next cycle", 64'(done), 64'd1);
        check(src_out === 64'h0000_1234_0000_0100, "R6 src unchanged", src_out, 64'h0000_1234_0000_0100);
        check(dst_out === 64'h200, "R6 dst unchanged", dst_out, 64'h200);
        repeat (3) @(negedge clk);
        check(n_rd == 0 && n_wr == 0, "R6 no memory access", 64'(n_rd + n_wr), 64'd0);
        check(!busy && !done, "R9 idle after zero-count done", {62'h0, busy, done}, 64'd0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        run_copy(64'h1000, 64'h2000, 5, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, "byte up");
        run_copy(64'h1100, 64'h2100, 6, 2'd1, 1'b1, 1'b0, 1'b1, 1'b0, "half down stall");
        run_copy(64'hABCD_0000_FFFF_FFF8, 64'h5555_0000_0000_3000, 4, 2'd2, 1'b0, 1'b1, 1'b1, 1'b0, "R5 word wrap up");
        run_copy(64'h0000_0000_0000_0008, 64'h9999_0000_0000_4010, 3, 2'd1, 1'b1, 1'b1, 1'b0, 1'b0, "R5 half wrap down");
        run_copy(64'h0001_0000_0000_1040, 64'h0001_0000_0000_5040, 3, 2'd3, 1'b1, 1'b0, 1'b1, 1'b0, "dword down");
        run_copy(64'h1200, 64'h2200, 3, 2'd2, 1'b0, 1'b0, 1'b0, 1'b1, "R8 start while busy");
        t_zero_count();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule